// File: doc/BRIEF.md
# Memory ECC Error Logger

This block sits next to the single-error-correct, double-error-detect check stage of a memory controller's read path. For every read, the check stage presents one status pulse. The pulse carries the syndrome, a flag that marks the error as uncorrectable, the flat address, and the DRAM position of the read: channel, slot, rank, bank, row and column. A zero syndrome means the read was clean, and the logger ignores it. Any other syndrome is an error. It is counted in one of two saturating counter arrays, correctable or uncorrectable, indexed by the chip-select rank and the channel.

The logger also keeps one error record with the full position of the error and its syndrome. The record holds the first error until software clears it, and later errors only set an overflow flag. There is one exception: an uncorrectable error may replace a pending correctable record, so the worse error is never lost. Uncorrectable errors also raise a sticky machine-check style interrupt. Software reaches everything through a single-cycle register port. Reads return record fields and counters one cycle after the request. Writes clear bits with write-one-to-clear semantics.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, all of the following are zero: the status word, every record field, every counter and `mce_irq`.
- R2: An event with `ev_valid` high and a zero syndrome changes neither the record, the status word, any counter nor `mce_irq`.
- R3: The first error after the record is empty is captured, and status bit 0 (valid) is set. The record is read at these word offsets: 0x01 flat address, 0x02 syndrome, 0x04 row, 0x05 column.
- R4: Offset 0x03 returns the packed position, least significant field first: bank in bits 3:0, rank in bits 5:4, slot in bit 6, channel in bit 7 (default widths).
- R5: Each error increments one counter. The counter index is rank*NUM_CH + channel. Correctable counts are read at 0x20+index and uncorrectable counts at 0x40+index.
- R6: An error that arrives while the record is valid sets status bit 2 (overflow). A correctable error arriving in that state leaves the record unchanged.
- R7: An uncorrectable error replaces a pending correctable record and sets status bit 1. A correctable error never replaces an uncorrectable record.
- R8: `mce_irq` rises one cycle after an uncorrectable error and is mirrored in status bit 3. Correctable errors do not raise it.
- R9: Writing ones to the status word clears the corresponding state. Bit 0 clears valid and the uncorrectable flag, bit 2 clears overflow, and bit 3 clears `mce_irq`.
- R10: A counter stops at its all-ones value and does not wrap.
- R11: A write with data bit 0 set to a counter offset clears that counter. A write with bit 0 clear has no effect.
- R12: `reg_rdata` is loaded on the clock edge where `reg_rd` is high. An unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Read status pulse |
| ev_uncorr | input | 1 | Error is uncorrectable |
| ev_synd | input | SYND_W | Syndrome |
| ev_addr | input | ADDR_W | Flat memory address |
| ev_chan | input | CH_W | Channel |
| ev_slot | input | SLOT_W | DIMM slot |
| ev_rank | input | RANK_W | Chip-select rank |
| ev_bank | input | BANK_W | Bank |
| ev_row | input | ROW_W | Row |
| ev_col | input | COL_W | Column |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word offset |
| reg_wdata | input | DATA_W | Write data (clear mask) |
| reg_rdata | output | DATA_W | Registered read data |
| mce_irq | output | 1 | Sticky uncorrectable-error interrupt |

## Verification
The hardest case to reach is a counter at its limit. With the default width it would take tens of thousands of errors. The bench therefore shrinks the counter width to three bits and drives nine errors into one index, which shows the counter stops at seven. The priority rule needs a set order of events: a correctable error, then a second one to set overflow, then an uncorrectable error that must take over the record, then a correctable error that must not. Between these steps the register port is read back.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_AW = 7;
  localparam logic [REG_AW-1:0] OFF_STATUS = 7'h00;
  localparam logic [REG_AW-1:0] OFF_ADDR   = 7'h01;
  localparam logic [REG_AW-1:0] OFF_SYND   = 7'h02;
  localparam logic [REG_AW-1:0] OFF_LOC    = 7'h03;
  localparam logic [REG_AW-1:0] OFF_ROW    = 7'h04;
  localparam logic [REG_AW-1:0] OFF_COL    = 7'h05;
  localparam logic [1:0] CE_PAGE = 2'b01;
  localparam logic [1:0] UE_PAGE = 2'b10;
  localparam int ST_VALID = 0;
  localparam int ST_UE    = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_IRQ   = 3;
endpackage

// File: rtl/ecc_sat_ctr_bank.sv
module ecc_sat_ctr_bank #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             clr,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int NUM = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NUM];

  for (genvar gi = 0; gi < NUM; gi++) begin : g_ctr
    logic             hit_inc, hit_clr;
    logic [CNT_W-1:0] base, nxt;
    always_comb begin
      hit_inc = inc && (inc_idx == IDX_W'(gi));
      hit_clr = clr && (clr_idx == IDX_W'(gi));
      base    = hit_clr ? '0 : cnt_q[gi];
      nxt     = (hit_inc && base != CMAX) ? base + 1'b1 : base;
    end
    always_ff @(posedge clk) begin
      if (rst) cnt_q[gi] <= '0;
      else     cnt_q[gi] <= nxt;
    end
  end

  assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/ecc_err_record.sv
module ecc_err_record #(
  parameter int SYND_W = 8,
  parameter int ADDR_W = 32,
  parameter int LOC_W  = 8,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              ue,
  input  logic [SYND_W-1:0] synd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LOC_W-1:0]  loc,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              clr_valid,
  input  logic              clr_ovf,
  output logic              rec_valid,
  output logic              rec_ue,
  output logic              rec_ovf,
  output logic [SYND_W-1:0] rec_synd,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [LOC_W-1:0]  rec_loc,
  output logic [ROW_W-1:0]  rec_row,
  output logic [COL_W-1:0]  rec_col
);
  logic base_v, base_ue, take;

  always_comb begin
    base_v  = rec_valid & ~clr_valid;
    base_ue = rec_ue & ~clr_valid;
    take    = hit && (!base_v || (ue && !base_ue));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_ue    <= 1'b0;
      rec_ovf   <= 1'b0;
      rec_synd  <= '0;
      rec_addr  <= '0;
      rec_loc   <= '0;
      rec_row   <= '0;
      rec_col   <= '0;
    end else begin
      rec_valid <= base_v | hit;
      rec_ue    <= take ? ue : base_ue;
      rec_ovf   <= (rec_ovf & ~clr_ovf) | (hit & base_v);
      if (take) begin
        rec_synd <= synd;
        rec_addr <= addr;
        rec_loc  <= loc;
        rec_row  <= row;
        rec_col  <= col;
      end
    end
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int SLOT_W = 1,
  parameter int RANK_W = 2,
  parameter int BANK_W = 4,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 10,
  parameter int SYND_W = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_uncorr,
  input  logic [SYND_W-1:0] ev_synd,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [RANK_W-1:0] ev_rank,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [COL_W-1:0]  ev_col,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [6:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mce_irq
);
  localparam int IDX_W = RANK_W + CH_W;
  localparam int LOC_W = CH_W + SLOT_W + RANK_W + BANK_W;

  logic              hit, ce_hit, ue_hit;
  logic [IDX_W-1:0]  ev_idx, rd_idx;
  logic              wr_status, ce_clr, ue_clr;
  logic [CNT_W-1:0]  ce_cnt, ue_cnt;
  logic              rec_valid, rec_ue, rec_ovf;
  logic [SYND_W-1:0] rec_synd;
  logic [ADDR_W-1:0] rec_addr;
  logic [LOC_W-1:0]  rec_loc;
  logic [ROW_W-1:0]  rec_row;
  logic [COL_W-1:0]  rec_col;
  logic              irq_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit       = ev_valid && (ev_synd != '0);
    ce_hit    = hit && !ev_uncorr;
    ue_hit    = hit && ev_uncorr;
    ev_idx    = IDX_W'(ev_rank * NUM_CH + ev_chan);
    rd_idx    = reg_addr[IDX_W-1:0];
    wr_status = reg_wr && (reg_addr == OFF_STATUS);
    ce_clr    = reg_wr && (reg_addr[6:5] == CE_PAGE) && reg_wdata[0];
    ue_clr    = reg_wr && (reg_addr[6:5] == UE_PAGE) && reg_wdata[0];
  end

  ecc_sat_ctr_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ce_ctr (
    .clk(clk), .rst(rst), .inc(ce_hit), .inc_idx(ev_idx),
    .clr(ce_clr), .clr_idx(rd_idx), .rd_idx(rd_idx), .rd_cnt(ce_cnt)
  );

  ecc_sat_ctr_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ue_ctr (
    .clk(clk), .rst(rst), .inc(ue_hit), .inc_idx(ev_idx),
    .clr(ue_clr), .clr_idx(rd_idx), .rd_idx(rd_idx), .rd_cnt(ue_cnt)
  );

  ecc_err_record #(
    .SYND_W(SYND_W), .ADDR_W(ADDR_W), .LOC_W(LOC_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_rec (
    .clk(clk), .rst(rst), .hit(hit), .ue(ev_uncorr), .synd(ev_synd),
    .addr(ev_addr), .loc({ev_chan, ev_slot, ev_rank, ev_bank}),
    .row(ev_row), .col(ev_col),
    .clr_valid(wr_status && reg_wdata[ST_VALID]),
    .clr_ovf(wr_status && reg_wdata[ST_OVF]),
    .rec_valid(rec_valid), .rec_ue(rec_ue), .rec_ovf(rec_ovf),
    .rec_synd(rec_synd), .rec_addr(rec_addr), .rec_loc(rec_loc),
    .rec_row(rec_row), .rec_col(rec_col)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (irq_q & ~(wr_status && reg_wdata[ST_IRQ])) | ue_hit;
  end
  assign mce_irq = irq_q;

  always_comb begin
    rd_mux = '0;
    if (reg_addr[6:5] == CE_PAGE && reg_addr[4:IDX_W] == '0) begin
      rd_mux = DATA_W'(ce_cnt);
    end else if (reg_addr[6:5] == UE_PAGE && reg_addr[4:IDX_W] == '0) begin
      rd_mux = DATA_W'(ue_cnt);
    end else begin
      case (reg_addr)
        OFF_STATUS: begin
          rd_mux[ST_VALID] = rec_valid;
          rd_mux[ST_UE]    = rec_ue;
          rd_mux[ST_OVF]   = rec_ovf;
          rd_mux[ST_IRQ]   = irq_q;
        end
        OFF_ADDR: rd_mux = DATA_W'(rec_addr);
        OFF_SYND: rd_mux = DATA_W'(rec_synd);
        OFF_LOC:  rd_mux = DATA_W'(rec_loc);
        OFF_ROW:  rd_mux = DATA_W'(rec_row);
        OFF_COL:  rd_mux = DATA_W'(rec_col);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int SYND_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ev_uncorr,
  input logic [SYND_W-1:0] ev_synd,
  input logic              reg_wr,
  input logic              rec_valid,
  input logic              rec_ue,
  input logic              rec_ovf,
  input logic              mce_irq
);
  logic err;
  assign err = ev_valid && (ev_synd != '0);

  // R2: clean reads leave record state alone
  p_clean_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_synd == '0 && !reg_wr) |=> $stable({rec_valid, rec_ue, rec_ovf, mce_irq}));

  // R3: an error always leaves the record valid
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    err |=> rec_valid);

  // R6: a second error while valid sets overflow
  p_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (err && rec_valid && !reg_wr) |=> rec_ovf);

  // R7: the uncorrectable flag is only lost through a software write
  p_ue_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_ue && !reg_wr) |=> rec_ue);

  // R8: uncorrectable errors raise the interrupt next cycle
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (err && ev_uncorr) |=> mce_irq);

  // R8: the interrupt never rises without an uncorrectable error
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!mce_irq && !(err && ev_uncorr)) |=> !mce_irq);
endmodule

bind ecc_err_log ecc_err_log_chk #(.SYND_W(SYND_W)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
  .ev_synd(ev_synd), .reg_wr(reg_wr), .rec_valid(rec_valid),
  .rec_ue(rec_ue), .rec_ovf(rec_ovf), .mce_irq(mce_irq)
);

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0, ev_uncorr = 1'b0;
  logic [7:0]  ev_synd = '0;
  logic [31:0] ev_addr = '0;
  logic        ev_chan = '0, ev_slot = '0;
  logic [1:0]  ev_rank = '0;
  logic [3:0]  ev_bank = '0;
  logic [17:0] ev_row = '0;
  logic [9:0]  ev_col = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mce_irq;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ecc_err_log #(.CNT_W(3)) u_ecc_err_log (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
    .ev_synd(ev_synd), .ev_addr(ev_addr), .ev_chan(ev_chan), .ev_slot(ev_slot),
    .ev_rank(ev_rank), .ev_bank(ev_bank), .ev_row(ev_row), .ev_col(ev_col),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mce_irq(mce_irq)
  );

  always @(posedge clk) rd_pend <= reg_rd;

  // monitor: compare read data one cycle after each read request
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ev(input logic ue, input logic [7:0] s, input logic [31:0] a,
                    input logic ch, input logic sl, input logic [1:0] rk,
                    input logic [3:0] bk, input logic [17:0] rw, input logic [9:0] cl);
    @(negedge clk);
    ev_valid = 1'b1; ev_uncorr = ue; ev_synd = s; ev_addr = a;
    ev_chan = ch; ev_slot = sl; ev_rank = rk; ev_bank = bk; ev_row = rw; ev_col = cl;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (mce_irq !== e) begin
      bad++;
      $display("FAIL %s: mce_irq got %b expected %b", t, mce_irq, e);
    end
  endtask

  task automatic drain;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(7'h00, 32'h0, "R1 status");
    rd(7'h01, 32'h0, "R1 addr");
    rd(7'h23, 32'h0, "R1 ce cnt");
    rd(7'h44, 32'h0, "R1 ue cnt");
    chk_irq(1'b0, "R1 irq");
    // R2 zero syndrome ignored
    ev(1'b1, 8'h00, 32'hDEAD0000, 1'b1, 1'b0, 2'd1, 4'd5, 18'h100, 10'h20);
    rd(7'h00, 32'h0, "R2 status");
    rd(7'h23, 32'h0, "R2 ce cnt");
    rd(7'h43, 32'h0, "R2 ue cnt");
    chk_irq(1'b0, "R2 irq");
    // R3 R4 R5 first correctable error: rank1 chan1 -> index 3
    ev(1'b0, 8'h13, 32'h8F32540A, 1'b1, 1'b0, 2'd1, 4'd5, 18'h17900, 10'h155);
    rd(7'h00, 32'h1, "R3 status");
    rd(7'h01, 32'h8F32540A, "R3 addr");
    rd(7'h02, 32'h13, "R3 synd");
    rd(7'h04, 32'h17900, "R3 row");
    rd(7'h05, 32'h155, "R3 col");
    rd(7'h03, 32'h95, "R4 loc");
    rd(7'h23, 32'h1, "R5 ce cnt idx3");
    rd(7'h43, 32'h0, "R5 ue cnt idx3");
    chk_irq(1'b0, "R8 no irq on ce");
    // R6 second correctable error: rank0 chan0 -> index 0
    ev(1'b0, 8'h22, 32'h00001111, 1'b0, 1'b1, 2'd0, 4'd2, 18'h5, 10'h6);
    rd(7'h00, 32'h5, "R6 status");
    rd(7'h01, 32'h8F32540A, "R6 addr kept");
    rd(7'h20, 32'h1, "R5 ce cnt idx0");
    // R7 R8 uncorrectable replaces record: rank2 chan0 -> index 4
    ev(1'b1, 8'h3C, 32'hCAFE0000, 1'b0, 1'b0, 2'd2, 4'd9, 18'h22, 10'h33);
    chk_irq(1'b1, "R8 irq on ue");
    rd(7'h00, 32'hF, "R7 status");
    rd(7'h01, 32'hCAFE0000, "R7 addr replaced");
    rd(7'h02, 32'h3C, "R7 synd replaced");
    rd(7'h44, 32'h1, "R5 ue cnt idx4");
    rd(7'h24, 32'h0, "R5 ce cnt idx4");
    // R7 correctable cannot replace: rank3 chan1 -> index 7
    ev(1'b0, 8'h01, 32'h12345678, 1'b1, 1'b1, 2'd3, 4'd1, 18'h1, 10'h1);
    rd(7'h01, 32'hCAFE0000, "R7 addr held");
    rd(7'h00, 32'hF, "R7 status held");
    // R9 status clear
    wr(7'h00, 32'hF);
    rd(7'h00, 32'h0, "R9 status cleared");
    chk_irq(1'b0, "R9 irq cleared");
    // R10 saturation at 7: index 0 already holds 1
    for (int i = 0; i < 9; i++)
      ev(1'b0, 8'h07, 32'h0, 1'b0, 1'b0, 2'd0, 4'd0, 18'h0, 10'h0);
    rd(7'h20, 32'h7, "R10 saturated");
    // R11 write with bit0 clear has no effect, bit0 set clears
    wr(7'h20, 32'hFFFFFFFE);
    rd(7'h20, 32'h7, "R11 no clear");
    wr(7'h20, 32'h1);
    rd(7'h20, 32'h0, "R11 cleared");
    rd(7'h27, 32'h1, "R11 other counter kept");
    // R12 unmapped offset
    rd(7'h10, 32'h0, "R12 unmapped");
    drain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule